// File: doc/BRIEF.md
# Stochastic Rounding Float Narrowing Unit

This unit narrows floating-point lanes to a smaller format by stochastic rounding. It does not round to nearest. Each lane takes a source value and a random word. The low random bits line up with the mantissa bits that will be discarded, so random bit 0 sits under source mantissa bit 0. They are added to the source significand, and the sum is truncated. A value therefore rounds up with a probability equal to the fraction it has lost.

Two conversions are provided:
- **Mode 0** narrows a 32-bit single to a 16-bit half. The exponent is rebiased from 127 to 15, and 13 random bits are used.
- **Mode 1** narrows a half to an 8-bit float. That format has 1 sign bit, 5 exponent bits and 2 mantissa bits. The exponent bias of 15 is kept, and 8 random bits are used.

The lane array is replicated `LANES` times. A three-bit lane-count code sets how many lanes take part, and a per-lane enable masks single lanes. Results are registered, so the unit has one cycle of latency.

Top module: `srnd_narrow_unit`

## Requirements
- R1: In mode 0, `src` bits 31:0 are read as a single. `rnd` bits 12:0 are added to the significand with the hidden bit included, and random bit 0 is aligned with mantissa bit 0. The sum is truncated by 13 bits. The exponent is rebiased from 127 to 15. The half result appears in `dst` lane bits 15:0 as {sign, 5-bit exponent, 10-bit mantissa}.
- R2: In mode 1, `src` bits 15:0 are read as a half. `rnd` bits 7:0 are added in the same aligned way, and the sum is truncated by 8 bits. The bias of 15 is kept. The result appears in `dst` lane bits 7:0 as {sign, 5-bit exponent, 2-bit mantissa}, and lane bits 15:8 are zero.
- R3: Random bits above the used width (31:13 in mode 0, 31:8 in mode 1) have no effect on the result.
- R4: When the addition carries out of the significand, the exponent is incremented. If the exponent then reaches all ones, the result is infinity with the source sign. The result never saturates to the largest finite value.
- R5: An infinite input gives infinity with the same sign. A NaN input gives a NaN with the same sign, an all-ones exponent, and the top mantissa bit set, even when truncation would clear every mantissa bit.
- R6: Inputs below the output normal range are shifted right together with their hidden bit before the random bits are added. Bits shifted out are dropped, and the result is a subnormal or a zero with the sign kept. Subnormal inputs are never flushed to zero.
- R7: Lane `i` is active when `lane_en[i]` is 1 and `i` is less than 2 to the power of `lane_cnt`. The codes 0 to 5 select 1, 2, 4, 8, 16 or 32 lanes. An inactive lane gives an all-zero result.
- R8: `out_valid` equals `in_valid` delayed by one cycle. `dst` is loaded only on cycles where `in_valid` is 1, and holds its value otherwise.
- R9: While `rst_n` is low, `out_valid` and `dst` are zero.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Lane operands are valid this cycle |
| mode | input | 1 | 0: single to half; 1: half to 8-bit float |
| lane_cnt | input | 3 | Lane-count code; lanes = 2^code |
| lane_en | input | LANES | Per-lane enable |
| src | input | LANES*32 | Source values, lane i at bits 32i+31:32i |
| rnd | input | LANES*32 | Random words, lane i at bits 32i+31:32i |
| out_valid | output | 1 | Registered result is valid |
| dst | output | LANES*16 | Results, lane i at bits 16i+15:16i |

## Verification
The assertions assume that `mode` and the lane slices of `src` are stable and known on any cycle where `in_valid` is high. They also assume that `lane_cnt` stays within codes 0 to 5.

The stimulus meets these assumptions by changing inputs only on the falling clock edge. It draws lane counts and mode bits inside the legal ranges. In half mode it keeps the upper source half at zero, so only legal half encodings reach the datapath.

Random exponents are steered toward the edges of the output range. This makes carries into infinity and shifts into the subnormal range occur often. The special values are also covered by directed cases.

// File: rtl/srnd_pkg.sv
package srnd_pkg;

    typedef enum logic {
        SRND_F32_TO_F16 = 1'b0,
        SRND_F16_TO_F8  = 1'b1
    } srnd_mode_e;

    localparam int unsigned SRND_SRC_W = 32;
    localparam int unsigned SRND_RND_W = 32;
    localparam int unsigned SRND_DST_W = 16;

endpackage

// File: rtl/srnd_convert.sv
module srnd_convert #(
    parameter int unsigned EWI   = 8,
    parameter int unsigned MWI   = 23,
    parameter int unsigned BIASI = 127,
    parameter int unsigned EWO   = 5,
    parameter int unsigned MWO   = 10,
    parameter int unsigned BIASO = 15
) (
    input  logic [EWI+MWI:0]     src,
    input  logic [MWI-MWO-1:0]   rnd,
    output logic [EWO+MWO:0]     dst
);
    localparam int unsigned DROP    = MWI - MWO;
    localparam int unsigned SW      = MWI + 2;
    localparam int unsigned KW      = MWO + 2;
    localparam int unsigned TEW     = ((EWI > EWO) ? EWI : EWO) + 3;
    localparam int unsigned EXP_MAX = (1 << EWO) - 1;

    logic                  sgn;
    logic [EWI-1:0]        e_in;
    logic [MWI-1:0]        m_in;
    logic                  hidden;
    logic                  is_special;
    logic [EWI-1:0]        e_eff;
    logic signed [TEW-1:0] te;
    logic signed [TEW-1:0] exp_w;
    logic [TEW-1:0]        sh;
    logic [SW-1:0]         sig;
    logic [SW-1:0]         sum;
    logic [KW-1:0]         kept;
    logic [MWO-1:0]        mant;

    assign {sgn, e_in, m_in} = src;
    assign hidden     = |e_in;
    assign is_special = &e_in;
    assign e_eff      = hidden ? e_in : EWI'(1);

    always_comb begin
        te  = signed'(TEW'(e_eff) - TEW'(BIASI) + TEW'(BIASO));
        sig = {1'b0, hidden, m_in};
        sh  = '0;
        if (te <= 0) begin
            sh  = TEW'(1) - unsigned'(te);
            sig = (sh >= TEW'(SW)) ? '0 : (sig >> sh);
            te  = signed'(TEW'(1));
        end
        sum  = sig + SW'(rnd);
        kept = sum[SW-1:DROP];
        if (kept[KW-1]) begin
            exp_w = te + signed'(TEW'(1));
            mant  = kept[MWO:1];
        end else if (kept[MWO]) begin
            exp_w = te;
            mant  = kept[MWO-1:0];
        end else begin
            exp_w = '0;
            mant  = kept[MWO-1:0];
        end

        if (is_special && (|m_in)) begin
            dst = {sgn, {EWO{1'b1}}, 1'b1, {(MWO-1){1'b0}}};
        end else if (is_special || (exp_w >= signed'(TEW'(EXP_MAX)))) begin
            dst = {sgn, {EWO{1'b1}}, {MWO{1'b0}}};
        end else begin
            dst = {sgn, exp_w[EWO-1:0], mant};
        end
    end

endmodule

// File: rtl/srnd_lane_mask.sv
module srnd_lane_mask #(
    parameter int unsigned LANES = 8
) (
    input  logic [2:0]       lane_cnt,
    input  logic [LANES-1:0] lane_en,
    output logic [LANES-1:0] lane_act
);
    localparam int unsigned SPW = 7;

    logic [SPW-1:0] span;

    assign span = (lane_cnt > 3'd5) ? SPW'(32) : (SPW'(1) << lane_cnt);

    for (genvar gi = 0; gi < LANES; gi++) begin : g_act
        assign lane_act[gi] = lane_en[gi] && (SPW'(gi) < span);
    end

endmodule

// File: rtl/srnd_lane.sv
module srnd_lane
    import srnd_pkg::*;
(
    input  logic                  mode,
    input  logic                  active,
    input  logic [SRND_SRC_W-1:0] src,
    input  logic [SRND_RND_W-1:0] rnd,
    output logic [SRND_DST_W-1:0] dst
);
    logic [15:0] half_res;
    logic [7:0]  byte_res;
    logic        rnd_unused;

    assign rnd_unused = ^rnd[SRND_RND_W-1:13];

    srnd_convert #(
        .EWI(8), .MWI(23), .BIASI(127), .EWO(5), .MWO(10), .BIASO(15)
    ) cvt_wide_i (
        .src (src),
        .rnd (rnd[12:0]),
        .dst (half_res)
    );

    srnd_convert #(
        .EWI(5), .MWI(10), .BIASI(15), .EWO(5), .MWO(2), .BIASO(15)
    ) cvt_narrow_i (
        .src (src[15:0]),
        .rnd (rnd[7:0]),
        .dst (byte_res)
    );

    always_comb begin
        if (!active) begin
            dst = '0;
        end else if (mode == SRND_F16_TO_F8) begin
            dst = {8'h00, byte_res};
        end else begin
            dst = half_res;
        end
    end

endmodule

// File: rtl/srnd_narrow_unit.sv
module srnd_narrow_unit
    import srnd_pkg::*;
#(
    parameter int unsigned LANES = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        mode,
    input  logic [2:0]                  lane_cnt,
    input  logic [LANES-1:0]            lane_en,
    input  logic [LANES*SRND_SRC_W-1:0] src,
    input  logic [LANES*SRND_RND_W-1:0] rnd,
    output logic                        out_valid,
    output logic [LANES*SRND_DST_W-1:0] dst
);
    logic [LANES-1:0]            lane_act;
    logic [LANES*SRND_DST_W-1:0] dst_d;

    srnd_lane_mask #(.LANES(LANES)) mask_i (
        .lane_cnt (lane_cnt),
        .lane_en  (lane_en),
        .lane_act (lane_act)
    );

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        srnd_lane lane_i (
            .mode   (mode),
            .active (lane_act[gi]),
            .src    (src[gi*SRND_SRC_W +: SRND_SRC_W]),
            .rnd    (rnd[gi*SRND_RND_W +: SRND_RND_W]),
            .dst    (dst_d[gi*SRND_DST_W +: SRND_DST_W])
        );

        logic [SRND_SRC_W-1:0] s_l;
        logic [SRND_DST_W-1:0] d_l;
        assign s_l = src[gi*SRND_SRC_W +: SRND_SRC_W];
        assign d_l = dst[gi*SRND_DST_W +: SRND_DST_W];

        assert_nan_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && lane_act[gi] && (mode == SRND_F32_TO_F16)
             && (&s_l[30:23]) && (|s_l[22:0]))
            |=> ((&d_l[14:10]) && d_l[9]));

        assert_inf_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && lane_act[gi] && (mode == SRND_F32_TO_F16)
             && (s_l[30:0] == 31'h7F80_0000))
            |=> ((d_l[14:0] == 15'h7C00) && (d_l[15] == $past(s_l[31]))));

        assert_inactive_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !lane_act[gi]) |=> (d_l == '0));

        assert_byte_upper_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (mode == SRND_F16_TO_F8)) |=> (d_l[15:8] == 8'h00));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            dst       <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dst <= dst_d;
            end
        end
    end

    assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(dst));

endmodule

// File: tb/srnd_narrow_unit_tb_top.sv
`timescale 1ns/1ps
module srnd_narrow_unit_tb_top;
    localparam int LANES = 8;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_valid = 1'b0;
    logic                  mode = 1'b0;
    logic [2:0]            lane_cnt = 3'd3;
    logic [LANES-1:0]      lane_en = '1;
    logic [31:0]           s_arr [LANES];
    logic [31:0]           r_arr [LANES];
    logic [LANES*32-1:0]   src_v;
    logic [LANES*32-1:0]   rnd_v;
    logic                  out_valid;
    logic [LANES*16-1:0]   dst;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            src_v[i*32 +: 32] = s_arr[i];
            rnd_v[i*32 +: 32] = r_arr[i];
        end
    end

    srnd_narrow_unit #(.LANES(LANES)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .lane_cnt(lane_cnt), .lane_en(lane_en), .src(src_v), .rnd(rnd_v),
        .out_valid(out_valid), .dst(dst)
    );

    function automatic logic [15:0] ref_conv(input logic m, input logic [31:0] s,
                                             input logic [31:0] r);
        int ewi, mwi, bi, ewo, mwo, bo, drop, e, oe, emax;
        longint unsigned sig, man, rr, q, val;
        logic sg;
        if (m == 1'b0) begin
            ewi = 8; mwi = 23; bi = 127; ewo = 5; mwo = 10; bo = 15;
        end else begin
            ewi = 5; mwi = 10; bi = 15; ewo = 5; mwo = 2; bo = 15;
        end
        drop = mwi - mwo;
        emax = (1 << ewo) - 1;
        sg   = s[ewi + mwi];
        e    = int'((s >> mwi) & ((32'd1 << ewi) - 1));
        man  = longint'(s & ((32'd1 << mwi) - 1));
        rr   = longint'(r & ((32'd1 << drop) - 1));
        if (e == (1 << ewi) - 1) begin
            q  = (man != 0) ? (64'd1 << (mwo - 1)) : 64'd0;
            oe = emax;
        end else begin
            sig = (e != 0) ? (man | (64'd1 << mwi)) : man;
            oe  = ((e != 0) ? e : 1) - bi + bo;
            while (oe < 1) begin
                sig = sig >> 1;
                oe  = oe + 1;
            end
            q = (sig + rr) >> drop;
            if (q >= (64'd1 << (mwo + 1))) begin
                q  = q >> 1;
                oe = oe + 1;
            end else if (q < (64'd1 << mwo)) begin
                oe = 0;
            end
            if (oe >= emax) begin
                oe = emax;
                q  = 0;
            end
        end
        val = (longint'(sg) << (ewo + mwo)) | (longint'(oe) << mwo)
            | (q & ((64'd1 << mwo) - 1));
        return 16'(val);
    endfunction

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%04h expected=%04h", tag, act, exp);
        end
    endtask

    // Drive one transaction, then compare every lane against the bench model.
    task automatic run_txn(input string tag);
        logic [15:0] exp;
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check16({tag, " valid R8"}, {15'd0, out_valid}, 16'd1);
        for (int i = 0; i < LANES; i++) begin
            if (lane_en[i] && (i < (1 << lane_cnt)))
                exp = ref_conv(mode, s_arr[i], r_arr[i]);
            else
                exp = 16'h0000;
            check16(tag, dst[i*16 +: 16], exp);
        end
    endtask

    // All lanes carry the same operands; the result is compared with a hand value.
    task automatic directed(input string tag, input logic m, input logic [31:0] s,
                            input logic [31:0] r, input logic [15:0] exp);
        @(negedge clk);
        mode = m; lane_cnt = 3'd3; lane_en = '1;
        for (int i = 0; i < LANES; i++) begin
            s_arr[i] = s;
            r_arr[i] = r;
        end
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < LANES; i++) check16(tag, dst[i*16 +: 16], exp);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5EED_0017);
        for (int i = 0; i < LANES; i++) begin
            s_arr[i] = 32'd0;
            r_arr[i] = 32'd0;
        end
        repeat (3) @(negedge clk);
        check16("R9 reset valid", {15'd0, out_valid}, 16'd0);
        check16("R9 reset dst", dst[15:0], 16'h0000);
        rst_n = 1'b1;

        directed("R1 one", 1'b0, 32'h3F80_0000, 32'h0000_1FFF, 16'h3C00);
        directed("R1 below two", 1'b0, 32'h3FFF_FFFF, 32'h0, 16'h3FFF);
        directed("R4 carry", 1'b0, 32'h3FFF_FFFF, 32'h1, 16'h4000);
        directed("R4 max finite", 1'b0, 32'h477F_FFFF, 32'h0, 16'h7BFF);
        directed("R4 to inf", 1'b0, 32'h477F_FFFF, 32'h1, 16'h7C00);
        directed("R4 to neg inf", 1'b0, 32'hC77F_FFFF, 32'h1, 16'hFC00);
        directed("R5 qnan", 1'b0, 32'h7FC0_0001, 32'h0, 16'h7E00);
        directed("R5 snan", 1'b0, 32'h7F80_0001, 32'h0, 16'h7E00);
        directed("R5 neg inf", 1'b0, 32'hFF80_0000, 32'h1FFF, 16'hFC00);
        directed("R6 min sub", 1'b0, 32'h3380_0000, 32'h0, 16'h0001);
        directed("R6 half sub up", 1'b0, 32'h3300_0000, 32'h1000, 16'h0001);
        directed("R6 neg zero", 1'b0, 32'hB300_0000, 32'h0, 16'h8000);
        directed("R3 wide", 1'b0, 32'h3F80_0000, 32'hFFFF_E000, 16'h3C00);
        directed("R2 one", 1'b1, 32'h0000_3C00, 32'h0, 16'h003C);
        directed("R2 round up", 1'b1, 32'h0000_3CFF, 32'h1, 16'h003D);
        directed("R6 sub kept", 1'b1, 32'h0000_0100, 32'h0, 16'h0001);
        directed("R4 narrow inf", 1'b1, 32'h0000_7BFF, 32'h1, 16'h007C);
        directed("R4 narrow max", 1'b1, 32'h0000_7BFF, 32'h0, 16'h007B);
        directed("R3 narrow", 1'b1, 32'h0000_3C00, 32'hFFFF_FF00, 16'h003C);
        directed("R5 narrow nan", 1'b1, 32'h0000_FC01, 32'h0, 16'h00FE);

        // R7: two lanes selected by code 1, one of them masked off
        @(negedge clk);
        mode = 1'b0; lane_cnt = 3'd1; lane_en = 8'b1111_1110;
        for (int i = 0; i < LANES; i++) begin
            s_arr[i] = 32'h3F80_0000;
            r_arr[i] = 32'h0;
        end
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check16("R7 masked lane", dst[15:0], 16'h0000);
        check16("R7 active lane", dst[31:16], 16'h3C00);
        for (int i = 2; i < LANES; i++) check16("R7 beyond count", dst[i*16 +: 16], 16'h0000);

        // R8: output holds while in_valid stays low
        held = dst[31:16];
        for (int i = 0; i < LANES; i++) s_arr[i] = 32'h4000_0000;
        lane_en = '1; lane_cnt = 3'd3;
        repeat (3) @(negedge clk);
        check16("R8 hold", dst[31:16], held);
        check16("R8 valid low", {15'd0, out_valid}, 16'd0);

        for (int t = 0; t < 300; t++) begin
            mode = 1'($urandom_range(0, 1));
            lane_cnt = 3'($urandom_range(0, 3));
            lane_en = LANES'($urandom);
            for (int i = 0; i < LANES; i++) begin
                logic [31:0] s;
                s = $urandom;
                if (mode == 1'b0) begin
                    if ($urandom_range(0, 3) != 0) s[30:23] = 8'($urandom_range(95, 150));
                end else begin
                    s[31:16] = 16'h0;
                end
                s_arr[i] = s;
                r_arr[i] = $urandom;
            end
            run_txn(mode ? "R2 random" : "R1 random");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule